// File: doc/BRIEF.md
# PHY Management Register File

This block is the register side of a 10/100 Ethernet transceiver as a management controller on the MAC side sees it. It holds sixteen 16-bit registers. Single-cycle command pulses read and write them. Each command carries a 5-bit transceiver address and a 5-bit register index. Only transceiver address 1 answers. A read to any other address returns all ones, and a write to any other address changes nothing.

The control, status, identifier and ability registers come up with fixed reset values. The status register and the two identifier registers cannot be written. Writing the control register with its top bit set reloads every register instead of storing the value.

An asynchronous link-up input is synchronised and then edge-detected. On each change of the synchronised level, the block sets or clears the link bit in the status register and updates the partner-ability register. A separate link-fail bit is refreshed by every read command. When scan mode is on, a link change also updates it straight away.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset the registers read as follows: index 0 = 0x1000, index 1 = 0x7868, index 2 = 0x2000, index 3 = 0x5C90, index 4 = 0x01E1, every other index = 0x0000. After reset, rd_valid = 0 and link_fail = 0.
- R2: A cmd_rd pulse gives rd_valid high for exactly the next cycle. rd_data in that cycle holds the addressed register as it stood when the command was taken.
- R3: A cmd_wr to transceiver address 1 with index 0 or 4..15 stores wr_data as given. For index 0 this holds only when bit 15 is clear.
- R4: Writes to index 1 (status), 2 and 3 (identifiers) are discarded.
- R5: A write with an index of 16 or above changes no register. A read with such an index returns 0x0000.
- R6: A read to any transceiver address other than 1 returns 0xFFFF. A write to such an address changes no register.
- R7: When the synchronised link goes up, status bit 2 is set and index 5 is ORed with 0x01E1.
- R8: When the synchronised link goes down, status bit 2 is cleared and index 5 is ANDed with 0x01FF.
- R9: A write to index 0 with bit 15 set reloads every register to its R1 value and discards the written value. Status bit 2 and index 5 then reflect the current link as in R7 and R8.
- R10: Every cmd_rd, at any transceiver address, loads link_fail with the inverse of the synchronised link one cycle later.
- R11: While scan_en is high, a change of the synchronised link loads link_fail with its inverse. While scan_en is low, link changes leave link_fail unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write command pulse |
| cmd_rd | input | 1 | Read command pulse |
| phy_addr | input | 5 | Target transceiver address |
| reg_addr | input | 5 | Register index |
| wr_data | input | 16 | Write data |
| scan_en | input | 1 | Continuous link-fail tracking enable |
| link_up_async | input | 1 | Asynchronous link-up level |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | Read data strobe |
| link_fail | output | 1 | Link-fail status bit |

## Verification
The assertions assume that cmd_rd and cmd_wr are single-cycle pulses. They also assume that link_up_async stays level long enough to pass the synchroniser, so every edge shows up as one change event. The stimulus drives commands as one-cycle pulses that never overlap. It changes the link only between commands and then waits several cycles before the next access, so link updates and register writes never meet in the same cycle.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam int IDX_CTRL    = 0;
    localparam int IDX_STAT    = 1;
    localparam int IDX_ID_HI   = 2;
    localparam int IDX_ID_LO   = 3;
    localparam int IDX_ADV     = 4;
    localparam int IDX_PARTNER = 5;

    localparam int    CTRL_RST_BIT = 15;
    localparam word_t CTRL_INIT    = 16'h1000;
    localparam word_t STAT_INIT    = 16'h7868;
    localparam word_t STAT_LINK    = 16'h0004;
    localparam word_t ID_HI_VAL    = 16'h2000;
    localparam word_t ID_LO_VAL    = 16'h5C90;
    localparam word_t ABILITY      = 16'h01E1;
    localparam word_t PARTNER_KEEP = 16'h01FF;
    localparam word_t FOREIGN_WORD = 16'hFFFF;

    typedef struct packed {
        logic  rd;
        addr_t phy;
        addr_t regad;
    } rd_cmd_t;

    typedef struct packed {
        logic  en;
        addr_t regad;
        word_t data;
    } wr_cmd_t;

    function automatic logic is_read_only(int idx);
        return (idx == IDX_STAT) || (idx == IDX_ID_HI) || (idx == IDX_ID_LO);
    endfunction

    function automatic word_t link_word(int idx, word_t cur, logic up);
        word_t r;
        r = cur;
        if (idx == IDX_STAT) begin
            r = up ? (cur | STAT_LINK) : (cur & ~STAT_LINK);
        end else if (idx == IDX_PARTNER) begin
            r = up ? (cur | ABILITY) : (cur & PARTNER_KEEP);
        end
        return r;
    endfunction

    function automatic word_t reset_word(int idx, logic up);
        word_t base;
        case (idx)
            IDX_CTRL:  base = CTRL_INIT;
            IDX_STAT:  base = STAT_INIT;
            IDX_ID_HI: base = ID_HI_VAL;
            IDX_ID_LO: base = ID_LO_VAL;
            IDX_ADV:   base = ABILITY;
            default:   base = '0;
        endcase
        return link_word(idx, base, up);
    endfunction

endpackage

// File: rtl/phy_link_sync.sv
module phy_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic link_async,
    output logic link_now,
    output logic link_chg
);
    logic [STAGES-1:0] chain;
    logic              link_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain     <= '0;
            link_prev <= 1'b0;
        end else begin
            chain     <= {chain[STAGES-2:0], link_async};
            link_prev <= chain[STAGES-1];
        end
    end

    assign link_now = chain[STAGES-1];
    assign link_chg = link_now ^ link_prev;
endmodule

// File: rtl/phy_reg_array.sv
module phy_reg_array
    import phy_mgmt_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_cmd_t                    wr,
    input  logic                       link_now,
    input  logic                       link_chg,
    output logic [NUM_REGS*WORD_W-1:0] regs_flat
);
    logic soft_rst;

    assign soft_rst = wr.en && (wr.regad == addr_t'(IDX_CTRL)) && wr.data[CTRL_RST_BIT];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        word_t cur;
        word_t nxt;

        always_comb begin
            nxt = cur;
            if (wr.en && (wr.regad == addr_t'(i)) && !is_read_only(i)) begin
                nxt = wr.data;
            end
            if (link_chg) begin
                nxt = link_word(i, nxt, link_now);
            end
        end

        always_ff @(posedge clk) begin
            if (rst || soft_rst) begin
                cur <= reset_word(i, link_now);
            end else begin
                cur <= nxt;
            end
        end

        assign regs_flat[i*WORD_W +: WORD_W] = cur;
    end
endmodule

// File: rtl/phy_read_port.sv
module phy_read_port
    import phy_mgmt_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int OWN_PHY  = 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  rd_cmd_t                    rd,
    input  logic [NUM_REGS*WORD_W-1:0] regs_flat,
    input  logic                       scan_en,
    input  logic                       link_now,
    input  logic                       link_chg,
    output word_t                      rd_data,
    output logic                       rd_valid,
    output logic                       link_fail
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [IDX_W-1:0] sel;
    word_t            picked;

    assign sel = rd.regad[IDX_W-1:0];

    always_comb begin
        if (rd.phy != addr_t'(OWN_PHY)) begin
            picked = FOREIGN_WORD;
        end else if (32'(rd.regad) < NUM_REGS) begin
            picked = regs_flat[sel*WORD_W +: WORD_W];
        end else begin
            picked = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            link_fail <= 1'b0;
        end else begin
            rd_valid <= rd.rd;
            if (rd.rd) begin
                rd_data <= picked;
            end
            if (rd.rd || (scan_en && link_chg)) begin
                link_fail <= ~link_now;
            end
        end
    end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int OWN_PHY     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  logic        cmd_rd,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    input  logic        scan_en,
    input  logic        link_up_async,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    output logic        link_fail
);
    logic                       link_now;
    logic                       link_chg;
    logic [NUM_REGS*WORD_W-1:0] regs_flat;
    wr_cmd_t                    wr;
    rd_cmd_t                    rd;

    assign wr.en    = cmd_wr && (phy_addr == addr_t'(OWN_PHY)) && (32'(reg_addr) < NUM_REGS);
    assign wr.regad = reg_addr;
    assign wr.data  = wr_data;
    assign rd.rd    = cmd_rd;
    assign rd.phy   = phy_addr;
    assign rd.regad = reg_addr;

    phy_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .link_async(link_up_async),
        .link_now(link_now), .link_chg(link_chg)
    );

    phy_reg_array #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .link_now(link_now),
        .link_chg(link_chg), .regs_flat(regs_flat)
    );

    phy_read_port #(.NUM_REGS(NUM_REGS), .OWN_PHY(OWN_PHY)) u_rd (
        .clk(clk), .rst(rst), .rd(rd), .regs_flat(regs_flat),
        .scan_en(scan_en), .link_now(link_now), .link_chg(link_chg),
        .rd_data(rd_data), .rd_valid(rd_valid), .link_fail(link_fail)
    );
endmodule

// File: rtl/phy_mgmt_checker.sv
module phy_mgmt_checker #(
    parameter int OWN_PHY = 1
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_rd,
    input logic [4:0]  phy_addr,
    input logic [15:0] rd_data,
    input logic        rd_valid,
    input logic        link_fail,
    input logic        link_now,
    input logic        link_chg,
    input logic [15:0] status_word,
    input logic [15:0] id_hi_word
);
    assert_rd_valid_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_rd |=> rd_valid);

    assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !cmd_rd |=> !rd_valid);

    assert_foreign_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_rd && phy_addr != 5'(OWN_PHY)) |=> rd_data == 16'hFFFF);

    assert_id_fixed_R4: assert property (@(posedge clk) disable iff (rst)
        id_hi_word == 16'h2000);

    assert_fail_refresh_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_rd |=> link_fail == !$past(link_now));

    assert_status_link_R7: assert property (@(posedge clk) disable iff (rst)
        link_chg |=> status_word[2] == $past(link_now));
endmodule

bind phy_mgmt_regfile phy_mgmt_checker #(.OWN_PHY(OWN_PHY)) u_chk (
    .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .phy_addr(phy_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .link_fail(link_fail),
    .link_now(link_now), .link_chg(link_chg),
    .status_word(regs_flat[31:16]), .id_hi_word(regs_flat[47:32])
);

// File: tb/tb_phy_mgmt_regfile.sv
`timescale 1ns/1ps
module tb_phy_mgmt_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic        cmd_rd = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        scan_en = 1'b0;
    logic        link_up_async = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        link_fail;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    phy_mgmt_regfile dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .scan_en(scan_en), .link_up_async(link_up_async),
        .rd_data(rd_data), .rd_valid(rd_valid), .link_fail(link_fail)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data whenever the strobe is seen
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected strobe", 16'd1, 16'd0);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic do_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        @(negedge clk);
        cmd_wr = 1'b1; phy_addr = phy; reg_addr = ra; wr_data = d;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cmd_rd = 1'b1; phy_addr = phy; reg_addr = ra;
        @(negedge clk);
        cmd_rd = 1'b0;
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_up_async = v;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd_valid after reset", 16'(rd_valid), 16'd0);
        chk("R1 link_fail after reset", 16'(link_fail), 16'd0);
        do_read(5'd1, 5'd0, 16'h1000, "R1 ctrl");
        do_read(5'd1, 5'd1, 16'h7868, "R1 status");
        do_read(5'd1, 5'd2, 16'h2000, "R1 id hi");
        do_read(5'd1, 5'd3, 16'h5C90, "R1 id lo");
        do_read(5'd1, 5'd4, 16'h01E1, "R1 adv");
        do_read(5'd1, 5'd5, 16'h0000, "R1 partner");
        do_read(5'd1, 5'd9, 16'h0000, "R1 other");
        @(negedge clk);
        chk("R10 read refresh link down", 16'(link_fail), 16'd1);
        // R3 writable registers
        do_write(5'd1, 5'd4, 16'hABCD);
        do_read(5'd1, 5'd4, 16'hABCD, "R3 idx4");
        do_write(5'd1, 5'd9, 16'h1234);
        do_read(5'd1, 5'd9, 16'h1234, "R3 idx9");
        do_write(5'd1, 5'd15, 16'hFFFF);
        do_read(5'd1, 5'd15, 16'hFFFF, "R3 idx15");
        do_write(5'd1, 5'd0, 16'h3100);
        do_read(5'd1, 5'd0, 16'h3100, "R3 ctrl no reset bit");
        // R4 read-only
        do_write(5'd1, 5'd1, 16'h0000);
        do_read(5'd1, 5'd1, 16'h7868, "R4 status");
        do_write(5'd1, 5'd2, 16'h0000);
        do_read(5'd1, 5'd2, 16'h2000, "R4 id hi");
        do_write(5'd1, 5'd3, 16'hFFFF);
        do_read(5'd1, 5'd3, 16'h5C90, "R4 id lo");
        // R5 out-of-range index
        do_write(5'd1, 5'd16, 16'h5555);
        do_read(5'd1, 5'd0, 16'h3100, "R5 aliased ctrl untouched");
        do_read(5'd1, 5'd16, 16'h0000, "R5 read out of range");
        // R6 foreign address
        do_write(5'd2, 5'd4, 16'h0000);
        do_read(5'd2, 5'd4, 16'hFFFF, "R6 foreign read");
        do_read(5'd1, 5'd4, 16'hABCD, "R6 foreign write ignored");
        // R7 link up, scan off
        do_write(5'd1, 5'd5, 16'hFE00);
        set_link(1'b1);
        chk("R11 no scan keeps link_fail", 16'(link_fail), 16'd1);
        do_read(5'd1, 5'd1, 16'h786C, "R7 status link set");
        do_read(5'd1, 5'd5, 16'hFFE1, "R7 partner ORed");
        @(negedge clk);
        chk("R10 read refresh link up", 16'(link_fail), 16'd0);
        // R8 link down, scan on
        do_write(5'd1, 5'd5, 16'hFFFF);
        scan_en = 1'b1;
        set_link(1'b0);
        chk("R11 scan link down", 16'(link_fail), 16'd1);
        do_read(5'd1, 5'd1, 16'h7868, "R8 status link clear");
        do_read(5'd1, 5'd5, 16'h01FF, "R8 partner masked");
        set_link(1'b1);
        chk("R11 scan link up", 16'(link_fail), 16'd0);
        // R9 soft reset
        do_write(5'd1, 5'd0, 16'h8000);
        do_read(5'd1, 5'd0, 16'h1000, "R9 ctrl reloaded");
        do_read(5'd1, 5'd4, 16'h01E1, "R9 adv reloaded");
        do_read(5'd1, 5'd9, 16'h0000, "R9 other cleared");
        do_read(5'd1, 5'd1, 16'h786C, "R9 status with link");
        do_read(5'd1, 5'd5, 16'h01E1, "R9 partner with link");
        repeat (3) @(negedge clk);
        chk("R2 queue drained", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule